// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames. Software writes a word into a holding register. The word moves into a private shift register as soon as the shifter is idle and the transmitter is enabled. Because of this, the next word can be written while the current frame is still leaving the pin. An empty flag tells the writer when the holding register can take new data.

The bit rate comes from the system clock divided by 32 times a 13-bit divisor. Each frame has:
- one low start bit;
- a data field of 8 or 9 bits, sent LSB first;
- one high stop bit.

When parity is enabled, the top bit of the data field carries an even or odd parity bit instead of data. The field size does not change.

Clearing the enable does not cut off a frame: the frame in progress completes. The output pin can run as a normal push-pull driver or as a wired-OR open-drain driver.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, `empty` is 1 and `ser_o` is 1 (idle high). With `tx_en` low, `ser_oe` is 0.
- R2: Every bit of a frame lasts exactly 32 × `divisor` clock cycles. A divisor of 0 acts as 1.
- R3: A frame is a low start bit, then the data field LSB first, then a high stop bit. `nine_bits`=0 gives 8 field bits and `nine_bits`=1 gives 9.
- R4: With `par_en`=1, the last field bit (bit 7 for 8-bit frames, bit 8 for 9-bit frames) is replaced by parity over the lower field bits. `par_odd`=0 makes the total count of ones in the field even, and `par_odd`=1 makes it odd.
- R5: A write (`wr_en`=1) sets `empty` to 0 on the next cycle. A transfer into the idle shifter with no write in the same cycle sets `empty` to 1.
- R6: A write accepted while a frame is shifting is held. It starts on the second clock after the previous stop bit ends, so exactly one idle-high cycle separates the two frames.
- R7: When `tx_en` falls during a frame, that frame completes unchanged. While `tx_en` is low, no new word leaves the holding register, and an idle output is released (`ser_oe`=0).
- R8: With `od_mode`=0, `ser_oe` is 1 whenever the transmitter is enabled or sending. With `od_mode`=1, `ser_oe` is 1 only while the line level is low.
- R9: A write while the holding register is already full replaces the held word. The earlier word is never sent.
- R10: The format inputs (`nine_bits`, `par_en`, `par_odd`) are captured when a word enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| nine_bits | input | 1 | Field length: 0 = 8 bits, 1 = 9 bits |
| par_en | input | 1 | Parity replaces the field MSB |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| od_mode | input | 1 | 1 = open-drain drive, 0 = push-pull drive |
| divisor | input | 13 | Rate divisor; bit time is 32 × divisor cycles |
| empty | output | 1 | Holding register can accept a word |
| ser_o | output | 1 | Serial line level |
| ser_oe | output | 1 | Output driver enable |

## Verification
The bench sends single words at divisors 0, 1 and 2 and measures the start-bit length; this separates a correct bit timer from one that is off by a cycle or ignores the zero case. Patterns with odd and even counts of ones, in both field lengths, show whether parity uses the right polarity and the right bit position. Back-to-back writes, an overwrite of a full holding register, and an enable drop in mid-frame check buffering, ordering and graceful stop. An open-drain frame together with mid-frame format changes checks drive control and capture of the format at load time.

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
  parameter int DIV_W = 13,
  parameter int OVS   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  input  logic             nine_bits,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             od_mode,
  input  logic [DIV_W-1:0] divisor,
  output logic             empty,
  output logic             ser_o,
  output logic             ser_oe
);
  localparam int CNT_W = DIV_W + $clog2(OVS);

  logic [8:0]       hold;
  logic             full;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bits_left;
  logic [10:0]      shreg;
  logic [8:0]       field;

  wire [DIV_W-1:0] div_eff   = (divisor == '0) ? DIV_W'(1) : divisor;
  wire [CNT_W-1:0] last_tick = CNT_W'(div_eff) * CNT_W'(OVS) - CNT_W'(1);

  always_comb begin
    field = hold;
    if (par_en) begin
      if (nine_bits) field[8] = (^hold[7:0]) ^ par_odd;
      else           field[7] = (^hold[6:0]) ^ par_odd;
    end
    if (!nine_bits) field[8] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      full      <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
      bits_left <= '0;
      shreg     <= '1;
    end else begin
      if (active) begin
        if (cnt >= last_tick) begin
          cnt   <= '0;
          shreg <= {1'b1, shreg[10:1]};
          if (bits_left == 4'd0) active <= 1'b0;
          else bits_left <= bits_left - 4'd1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else if (full && tx_en) begin
        shreg     <= {1'b1, field, 1'b0};
        active    <= 1'b1;
        cnt       <= '0;
        bits_left <= nine_bits ? 4'd10 : 4'd9;
        full      <= 1'b0;
      end
      if (wr_en) begin
        hold <= wr_data;
        full <= 1'b1;
      end
    end
  end

  assign empty  = ~full;
  assign ser_o  = active ? shreg[0] : 1'b1;
  assign ser_oe = (tx_en | active) & (~od_mode | ~ser_o);
endmodule

module ser_tx_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             wr_en,
  input logic             od_mode,
  input logic             empty,
  input logic             ser_o,
  input logic             ser_oe,
  input logic             active,
  input logic [CNT_W-1:0] cnt
);
  p_empty_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty);
  p_empty_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && !$past(wr_en)) |-> empty);
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !ser_o);
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && cnt != '0) |-> $stable(ser_o));
  p_od_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mode && ser_o) |-> !ser_oe);
  p_idle_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !active) |-> !ser_oe);
endmodule

bind ser_tx_dbuf ser_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .od_mode(od_mode),
  .empty(empty), .ser_o(ser_o), .ser_oe(ser_oe), .active(active), .cnt(cnt)
);

// File: tb/test_ser_tx_dbuf.sv
module test_ser_tx_dbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, wr_en = 1'b0, nine_bits = 1'b0, par_en = 1'b0, par_odd = 1'b0, od_mode = 1'b0;
  logic [8:0] wr_data = '0;
  logic [12:0] divisor = 13'd1;
  logic empty, ser_o, ser_oe;

  always #2.5 clk = ~clk;

  ser_tx_dbuf i_ser_tx_dbuf (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
    .nine_bits(nine_bits), .par_en(par_en), .par_odd(par_odd), .od_mode(od_mode),
    .divisor(divisor), .empty(empty), .ser_o(ser_o), .ser_oe(ser_oe)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  bit q[$];
  int m_cnt = 0;
  bit m_full = 0;
  logic [8:0] m_hold = '0;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_full = 0; m_hold = '0;
    end else begin
      int per;
      per = 32 * ((divisor == 0) ? 1 : int'(divisor));
      if (q.size() > 0) begin
        if (m_cnt >= per - 1) begin m_cnt = 0; void'(q.pop_front()); end
        else m_cnt++;
      end else if (m_full && tx_en) begin
        int n;
        int ones;
        n = nine_bits ? 9 : 8;
        ones = 0;
        q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
          bit b;
          b = m_hold[i];
          if (par_en && i == n - 1) b = ((ones % 2) == 1) ^ par_odd;
          ones += b;
          q.push_back(b);
        end
        q.push_back(1'b1);
        m_cnt = 0;
        m_full = 0;
      end
      if (wr_en) begin m_hold = wr_data; m_full = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic line;
      line = (q.size() > 0) ? q[0] : 1'b1;
      check({cur_req, " R5 empty"}, empty, !m_full);
      check({cur_req, " R3 line"}, ser_o, line);
      check({cur_req, " R8 oe"}, ser_oe, (tx_en || q.size() > 0) && (!od_mode || !line));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [8:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    step(1);
    while (q.size() > 0 || (m_full && tx_en)) step(1);
    step(2);
  endtask

  task automatic measure_start(string req, int exp);
    int low;
    low = 0;
    while (ser_o !== 1'b0) @(negedge clk);
    while (ser_o === 1'b0) begin low++; @(negedge clk); end
    check(req, low == exp, 1'b1);
  endtask

  initial begin
    step(3);
    cur_req = "R1";
    check("R1 empty", empty, 1'b1);
    check("R1 line", ser_o, 1'b1);
    check("R1 oe", ser_oe, 1'b0);
    rst_n = 1'b1;
    step(2);
    check("R1 empty after release", empty, 1'b1);

    cur_req = "R3";
    tx_en = 1'b1; divisor = 13'd1;
    wr(9'h0A5); drain();
    nine_bits = 1'b1; wr(9'h15A); drain();

    cur_req = "R2";
    nine_bits = 1'b0; divisor = 13'd2;
    fork wr(9'h0FF); measure_start("R2 start bit div2", 64); join
    drain();
    divisor = 13'd0;
    fork wr(9'h0FF); measure_start("R2 start bit div0", 32); join
    drain();
    divisor = 13'd1;

    cur_req = "R4";
    par_en = 1'b1; par_odd = 1'b0; wr(9'h035); drain();
    par_odd = 1'b1; wr(9'h035); drain();
    nine_bits = 1'b1; wr(9'h0F1); drain();
    par_odd = 1'b0; wr(9'h1F0); drain();
    par_en = 1'b0; nine_bits = 1'b0;

    cur_req = "R6";
    wr(9'h011); step(3); wr(9'h0C3);
    check("R6 held word", empty, 1'b0);
    drain();

    cur_req = "R9";
    wr(9'h022); step(3); wr(9'h044); step(5); wr(9'h088);
    drain();

    cur_req = "R7";
    wr(9'h066); step(40); tx_en = 1'b0; wr(9'h099);
    drain(); step(400);
    check("R7 word kept", empty, 1'b0);
    check("R7 released", ser_oe, 1'b0);
    tx_en = 1'b1; drain();

    cur_req = "R8";
    od_mode = 1'b1; wr(9'h05A); drain(); od_mode = 1'b0;

    cur_req = "R10";
    wr(9'h0B7); step(50);
    nine_bits = 1'b1; par_en = 1'b1; par_odd = 1'b1;
    drain();
    nine_bits = 1'b0; par_en = 1'b0; par_odd = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule